// File: doc/BRIEF.md
# Bit-Sliced Ripple Integer ALU

This block is a purely combinational integer arithmetic logic unit. It is built from one single-bit slice that is repeated across the word. Every slice holds two optional operand inverters, an AND gate, an OR gate, a full adder and a four-way output selector. The adder carries ripple from the least significant slice to the most significant one. Two shared inversion controls and a carry-in into bit 0 let this one slice structure produce AND, OR, addition, subtraction, NOR and a signed set-on-less-than.

A caller places two operands and a 4-bit control code on the inputs. In the same cycle, without any clock, the block returns the result word, a zero flag, a signed overflow flag and the adder's carry out.

The control code is split into fields. Bit 3 inverts operand A. Bit 2 inverts operand B and also feeds the carry into bit 0. Bits 1:0 choose the slice output: 0 is AND, 1 is OR, 2 is sum, and 3 is the less-than input. The block has no storage, so no data is held across cycles and no flow control is needed at its edge. Any code not listed in the requirements produces whatever the slice structure yields for that code, and no error is flagged.

Top module: `alu_ripple32`

## Requirements
- R1: With control 4'b0000 the result is the bitwise AND of the two operands.
- R2: With control 4'b0001 the result is the bitwise OR of the two operands.
- R3: With control 4'b0010 the result is the sum of the operands modulo 2^WIDTH, and carry_out is bit WIDTH of the full unsigned sum.
- R4: With control 4'b0110 the result is A minus B modulo 2^WIDTH. It is formed as A plus the inverse of B plus 1, so carry_out is 1 exactly when A is greater than or equal to B as unsigned numbers.
- R5: With control 4'b0111 the result is 1 when A is less than B as signed two's-complement numbers, and 0 otherwise. The answer stays correct when the internal subtraction overflows. Bits WIDTH-1:1 of the result are always 0 for this code.
- R6: With control 4'b1100 the result is the bitwise NOR of the operands.
- R7: zero is 1 exactly when every bit of the result is 0, for every control code.
- R8: overflow is 1 when the control code's low two bits are 2'b10 and the signed addition or subtraction overflows. Overflow means the carry into the top bit differs from the carry out of it. For all other control codes, overflow is 0.
- R9: All outputs follow the inputs combinationally in the same cycle, with no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| ctrl | input | 4 | Bit 3 inverts A; bit 2 inverts B and feeds the bit-0 carry-in; bits 1:0 choose the slice output |
| result | output | WIDTH | Result word |
| zero | output | 1 | High when the result is all zeros |
| overflow | output | 1 | Signed overflow for add and subtract; 0 otherwise |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
This block holds no state, so any fault shows up at the ports within the cycle that presents the operands. A broken link in the carry chain corrupts the sums at and above that bit. It also upsets carry_out and the set-on-less-than bit, and it is exposed by operands that carry across the whole word, such as all ones plus one. A wrong less-than feedback path appears only near the signed extremes. Wrong overflow gating appears on the logical codes. For this reason, corner operands at 0, 1, the largest positive value, the most negative value and all ones are paired exhaustively before random patterns are applied.

// File: rtl/alu_ripple_pkg.sv
package alu_ripple_pkg;

  // Slice output choice carried by ctrl[1:0]
  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } pick_e;

  // Field view of the 4-bit control code
  typedef struct packed {
    logic  inv_a;
    logic  inv_b;
    pick_e pick;
  } ctrl_t;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_ripple_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  inv_a_i,
  input  logic  inv_b_i,
  input  logic  carry_i,
  input  logic  less_i,
  input  pick_e pick_i,
  output logic  res_o,
  output logic  sum_o,
  output logic  carry_o
);

  logic a_eff;
  logic b_eff;
  logic and_v;
  logic or_v;

  // Operand conditioning ahead of gates and adder
  assign a_eff = inv_a_i ? ~a_i : a_i;
  assign b_eff = inv_b_i ? ~b_i : b_i;

  assign and_v = a_eff & b_eff;
  assign or_v  = a_eff | b_eff;

  // Full adder
  assign sum_o   = a_eff ^ b_eff ^ carry_i;
  assign carry_o = (a_eff & b_eff) | (a_eff & carry_i) | (b_eff & carry_i);

  always_comb begin
    unique case (pick_i)
      PICK_AND:  res_o = and_v;
      PICK_OR:   res_o = or_v;
      PICK_SUM:  res_o = sum_o;
      PICK_LESS: res_o = less_i;
      default:   res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_msb_flags.sv
module alu_msb_flags
  import alu_ripple_pkg::*;
(
  input  logic  carry_into_top_i,
  input  logic  carry_out_top_i,
  input  logic  sum_top_i,
  input  pick_e pick_i,
  output logic  set_o,
  output logic  overflow_o
);

  logic ovf_raw;

  assign ovf_raw = carry_into_top_i ^ carry_out_top_i;

  // Corrected sign of A-B, valid even when the subtraction wraps
  assign set_o = sum_top_i ^ ovf_raw;

  // Flag reported only for arithmetic selection
  assign overflow_o = (pick_i == PICK_SUM) ? ovf_raw : 1'b0;

endmodule

// File: rtl/alu_zero_tree.sv
module alu_zero_tree #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  assign zero_o = ~(|vec_i);

endmodule

// File: rtl/alu_ripple32.sv
module alu_ripple32
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);

  localparam int TOP = WIDTH - 1;

  ctrl_t            cfg;
  logic [WIDTH-1:0] cin_v;
  logic [WIDTH-1:0] cout_v;
  logic [WIDTH-1:0] sum_v;
  logic [WIDTH-1:0] less_v;
  logic             set_bit;

  assign cfg = ctrl_t'(ctrl);

  // Carry-in of bit 0 doubles as the +1 of two's-complement negation
  assign cin_v[0] = cfg.inv_b;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_slice
      if (g == 0) begin : g_lsb
        assign less_v[g] = set_bit;
      end else begin : g_upper
        assign less_v[g] = 1'b0;
        assign cin_v[g]  = cout_v[g-1];
      end

      alu_bit_slice u_slice (
        .a_i     (op_a[g]),
        .b_i     (op_b[g]),
        .inv_a_i (cfg.inv_a),
        .inv_b_i (cfg.inv_b),
        .carry_i (cin_v[g]),
        .less_i  (less_v[g]),
        .pick_i  (cfg.pick),
        .res_o   (result[g]),
        .sum_o   (sum_v[g]),
        .carry_o (cout_v[g])
      );
    end
  endgenerate

  alu_msb_flags u_msb (
    .carry_into_top_i (cin_v[TOP]),
    .carry_out_top_i  (cout_v[TOP]),
    .sum_top_i        (sum_v[TOP]),
    .pick_i           (cfg.pick),
    .set_o            (set_bit),
    .overflow_o       (overflow)
  );

  alu_zero_tree #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result),
    .zero_o (zero)
  );

  assign carry_out = cout_v[TOP];

endmodule

// File: rtl/alu_ripple32_chk.sv
module alu_ripple32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       ctrl,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carry_out
);

  always_comb begin
    // R1
    and_res_chk: assert (ctrl != 4'b0000 || result == (op_a & op_b));
    // R2
    or_res_chk: assert (ctrl != 4'b0001 || result == (op_a | op_b));
    // R3
    add_sum_chk: assert (ctrl != 4'b0010 ||
                         {carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}));
    // R4
    sub_diff_chk: assert (ctrl != 4'b0110 ||
                          (result == op_a - op_b && carry_out == (op_a >= op_b)));
    // R5
    slt_res_chk: assert (ctrl != 4'b0111 ||
                         result == {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
    // R6
    nor_res_chk: assert (ctrl != 4'b1100 || result == ~(op_a | op_b));
    // R8
    no_overflow_chk: assert (ctrl[1:0] == 2'b10 || !overflow);
  end

endmodule

bind alu_ripple32 alu_ripple32_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .ctrl      (ctrl),
  .result    (result),
  .zero      (zero),
  .overflow  (overflow),
  .carry_out (carry_out)
);

// File: tb/alu_ripple32_bench.sv
module alu_ripple32_bench;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [3:0]   ctrl;
  logic [W-1:0] result;
  logic         zero;
  logic         overflow;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  alu_ripple32 #(.WIDTH(W)) u_alu_ripple32 (
    .op_a      (op_a),
    .op_b      (op_b),
    .ctrl      (ctrl),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (ctrl=%b a=%h b=%h)",
               req, what, act, exp, ctrl, op_a, op_b);
    end
  endtask

  // Behavioural reference computed with wide integers
  task automatic apply(input logic [3:0] code, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    longint ua;
    longint ub;
    longint sa;
    longint sb;
    longint exp_r;
    longint exp_ovf;
    longint full;
    string  tag;
    @(posedge clk);
    #1;
    ctrl = code; op_a = a; op_b = b;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    exp_ovf = 0;
    full = 0;
    case (code)
      4'b0000: begin exp_r = ua & ub;                 tag = "R1"; end
      4'b0001: begin exp_r = ua | ub;                 tag = "R2"; end
      4'b0010: begin
        full = ua + ub; exp_r = full & 64'hFFFF_FFFF; tag = "R3";
        exp_ovf = ((sa + sb) > 64'sd2147483647 || (sa + sb) < -64'sd2147483648) ? 1 : 0;
      end
      4'b0110: begin
        exp_r = (ua - ub) & 64'hFFFF_FFFF;            tag = "R4";
        exp_ovf = ((sa - sb) > 64'sd2147483647 || (sa - sb) < -64'sd2147483648) ? 1 : 0;
      end
      4'b0111: begin exp_r = (sa < sb) ? 1 : 0;        tag = "R5"; end
      default: begin exp_r = (~(ua | ub)) & 64'hFFFF_FFFF; tag = "R6"; end
    endcase
    @(negedge clk);
    check(tag, "result", longint'(result), exp_r);
    check("R7", "zero", longint'(zero), (exp_r == 0) ? 1 : 0);
    check("R8", "overflow", longint'(overflow), exp_ovf);
    if (code == 4'b0010)
      check("R3", "carry_out", longint'(carry_out), (full >> 32) & 1);
    if (code == 4'b0110)
      check("R4", "carry_out", longint'(carry_out), (ua >= ub) ? 1 : 0);
  endtask

  logic [W-1:0] corners [6];
  logic [3:0]   codes   [6];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h5555_AAAA;
    codes[0] = 4'b0000; codes[1] = 4'b0001; codes[2] = 4'b0010;
    codes[3] = 4'b0110; codes[4] = 4'b0111; codes[5] = 4'b1100;

    rst_n = 1'b0;
    ctrl = 4'b0000; op_a = '0; op_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Initial state: AND of zeros gives a zero result, zero flag set (R1, R7, R9)
    check("R1", "reset result", longint'(result), 0);
    check("R7", "reset zero", longint'(zero), 1);
    rst_n = 1'b1;

    // Exhaustive corner pairs for every defined code
    for (int c = 0; c < 6; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(codes[c], corners[i], corners[j]);

    // Full-word carry ripple, equality and overflowing compare
    apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);   // R3 carry across all slices
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);   // R7 equality via subtract
    apply(4'b0111, 32'h8000_0000, 32'h0000_0001);   // R5 with internal overflow
    apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);   // R5 positive vs -1

    // Random patterns; each step depends only on current inputs (R9)
    for (int k = 0; k < 600; k++)
      apply(codes[k % 6], $urandom, $urandom);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule